// File: doc/BRIEF.md
# Programmable Four-Input Logic Cell with Serial Configuration

This block is one tile of a programmable logic fabric. A sixteen-entry truth table turns the four logic inputs into one result bit, so any Boolean function of four variables can be realised. A configuration bit picks the cell output. With the bit clear the output is the table result, straight through with no register. With the bit set the output comes from a flip-flop that samples the table result on each rising clock edge and holds it in between.

The truth table, the output-select bit and an initial value for the flip-flop are all kept in one 18-bit serial shift chain. While the configuration enable is high, one bit enters the chain from the serial input on every clock edge. The oldest bit in the chain leaves on the serial output, so many identical cells can be strung together and loaded from a single stream. The cell output is held low for the whole load. When the enable drops, the flip-flop takes its configured starting value, and normal operation then begins.

Top module: `logic_tile_cell`

## Requirements
- R1: While `cfgEn` is high, every rising clock edge shifts `cfgIn` into the chain. After 18 such edges the chain holds the loaded stream in this order: the first bit shifted in is the flip-flop initial value, the second is the output-select bit, and the remaining sixteen are table entries 15 down to 0, so the last bit shifted in is entry 0.
- R2: While `cfgEn` is low the chain keeps its contents at every edge, and `cfgIn` has no effect on `cfgOut` or on `cellOut`.
- R3: With the output-select bit at 0 and the cell in run mode, `cellOut` equals table entry k combinationally, where k is `lutIn` read as an unsigned number with `lutIn[3]` as the most significant bit.
- R4: With the output-select bit at 1 and the cell in run mode, `cellOut` is the table entry that was addressed at the previous rising edge. The value changes only at rising edges.
- R5: `cellOut` is 0 while `cfgEn` is high. It stays 0 up to the first rising edge at which `cfgEn` is sampled low.
- R6: At that first edge with `cfgEn` low, the flip-flop loads the configured initial value instead of the table result. While `cfgEn` is high the flip-flop holds its value.
- R7: `cfgOut` always shows the oldest chain bit, the initial-value position. It changes only on edges at which the chain shifts.
- R8: When `rstN` is low, the chain and the flip-flop are cleared at once, without waiting for a clock edge, and `cfgOut` and `cellOut` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgEn | input | 1 | Configuration enable; high shifts the chain |
| cfgIn | input | 1 | Serial configuration data in |
| lutIn | input | 4 | Logic inputs that address the truth table |
| cfgOut | output | 1 | Serial configuration data out, for daisy-chaining |
| cellOut | output | 1 | Cell result, from the table or from the flip-flop |

## Verification
Two events can land on the same edge: the load of the initial value and the ordinary capture of the table result. Both happen at the first edge after `cfgEn` falls. The bench sets this up with a registered configuration whose initial value differs from the table entry addressed in the release cycle. It then expects the initial value in the next cycle, not the table result. The scoreboard also covers the cycle when the enable drops: the output must still read 0 until that edge.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  // Default number of logic inputs of one cell.
  parameter int DEFAULT_LUT_INPUTS = 4;

  // Strobes from the configuration control to the datapath.
  typedef struct packed {
    logic shiftEn;    // move the chain by one position
    logic loadInit;   // flip-flop takes its configured start value
    logic captureEn;  // flip-flop samples the table result
    logic forceZero;  // hold the cell output low
  } cellStrobes_t;

  // Phase of the configuration control.
  typedef enum logic {
    PH_RUN   = 1'b0,
    PH_SHIFT = 1'b1
  } cfgPhase_t;

endpackage

// File: rtl/lut_mux_tree.sv
module lut_mux_tree #(
  parameter int SEL_BITS = 4
) (
  input  logic [(1<<SEL_BITS)-1:0] tableBits,
  input  logic [SEL_BITS-1:0]      sel,
  output logic                     result
);

  localparam int LEAVES = 1 << SEL_BITS;

  // Level 0 holds the stored bits. Each later level halves the width,
  // steered by one select bit, starting from the least significant one.
  for (genvar lv = 0; lv <= SEL_BITS; lv++) begin : g_lvl
    logic [(LEAVES >> lv)-1:0] node;
    if (lv == 0) begin : g_leaf
      assign node = tableBits;
    end else begin : g_mux
      for (genvar i = 0; i < (LEAVES >> lv); i++) begin : g_pair
        assign node[i] = sel[lv-1] ? g_lvl[lv-1].node[2*i+1]
                                   : g_lvl[lv-1].node[2*i];
      end
    end
  end

  assign result = g_lvl[SEL_BITS].node[0];

endmodule

// File: rtl/lut_cell_ctrl.sv
module lut_cell_ctrl
  import lut_cell_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgEn,
  output cellStrobes_t strobes
);

  cfgPhase_t phaseQ;

  // Records whether the previous edge saw the configuration enable high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_RUN;
    end else begin
      phaseQ <= cfgEn ? PH_SHIFT : PH_RUN;
    end
  end

  logic releaseEdge;
  assign releaseEdge = !cfgEn && (phaseQ == PH_SHIFT);

  always_comb begin
    strobes           = '0;
    strobes.shiftEn   = cfgEn;
    strobes.loadInit  = releaseEdge;
    strobes.captureEn = !cfgEn && (phaseQ == PH_RUN);
    strobes.forceZero = cfgEn || (phaseQ == PH_SHIFT);
  end

endmodule

// File: rtl/lut_cell_datapath.sv
module lut_cell_datapath
  import lut_cell_pkg::*;
#(
  parameter int LUT_INPUTS = DEFAULT_LUT_INPUTS
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgIn,
  input  logic [LUT_INPUTS-1:0]          lutIn,
  input  cellStrobes_t                   strobes,
  output logic                           cfgOut,
  output logic                           cellOut,
  output logic [(1<<LUT_INPUTS)+1:0]     chainBits,
  output logic                           regQ
);

  localparam int TABLE_DEPTH = 1 << LUT_INPUTS;
  localparam int CHAIN_LEN   = TABLE_DEPTH + 2;
  localparam int SEL_POS     = TABLE_DEPTH;
  localparam int INIT_POS    = TABLE_DEPTH + 1;

  logic [CHAIN_LEN-1:0]   chainQ;
  logic [TABLE_DEPTH-1:0] tableBits;
  logic                   outSel;
  logic                   initVal;
  logic                   lutResult;

  // Configuration chain: new bits enter at position 0, oldest leaves at the top.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ <= '0;
    end else if (strobes.shiftEn) begin
      chainQ <= {chainQ[CHAIN_LEN-2:0], cfgIn};
    end
  end

  assign tableBits = chainQ[TABLE_DEPTH-1:0];
  assign outSel    = chainQ[SEL_POS];
  assign initVal   = chainQ[INIT_POS];

  lut_mux_tree #(
    .SEL_BITS (LUT_INPUTS)
  ) u_tree (
    .tableBits (tableBits),
    .sel       (lutIn),
    .result    (lutResult)
  );

  // Cell flip-flop.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= 1'b0;
    end else if (strobes.loadInit) begin
      regQ <= initVal;
    end else if (strobes.captureEn) begin
      regQ <= lutResult;
    end
  end

  always_comb begin
    if (strobes.forceZero) begin
      cellOut = 1'b0;
    end else if (outSel) begin
      cellOut = regQ;
    end else begin
      cellOut = lutResult;
    end
  end

  assign cfgOut    = chainQ[CHAIN_LEN-1];
  assign chainBits = chainQ;

endmodule

// File: rtl/logic_tile_cell.sv
module logic_tile_cell
  import lut_cell_pkg::*;
#(
  parameter int LUT_INPUTS = DEFAULT_LUT_INPUTS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgEn,
  input  logic                  cfgIn,
  input  logic [LUT_INPUTS-1:0] lutIn,
  output logic                  cfgOut,
  output logic                  cellOut
);

  localparam int CHAIN_LEN = (1 << LUT_INPUTS) + 2;

  cellStrobes_t         strobes;
  logic [CHAIN_LEN-1:0] chainBits;
  logic                 regQ;

  lut_cell_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgEn   (cfgEn),
    .strobes (strobes)
  );

  lut_cell_datapath #(
    .LUT_INPUTS (LUT_INPUTS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgIn     (cfgIn),
    .lutIn     (lutIn),
    .strobes   (strobes),
    .cfgOut    (cfgOut),
    .cellOut   (cellOut),
    .chainBits (chainBits),
    .regQ      (regQ)
  );

endmodule

// File: rtl/logic_tile_cell_checker.sv
module logic_tile_cell_checker #(
  parameter int LUT_INPUTS = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          cfgEn,
  input logic [LUT_INPUTS-1:0]         lutIn,
  input logic                          cfgOut,
  input logic                          cellOut,
  input logic [(1<<LUT_INPUTS)+1:0]    chainBits,
  input logic                          regQ
);

  localparam int TABLE_DEPTH = 1 << LUT_INPUTS;
  localparam int CHAIN_LEN   = TABLE_DEPTH + 2;

  logic [TABLE_DEPTH-1:0] tableView;
  logic                   selView;
  assign tableView = chainBits[TABLE_DEPTH-1:0];
  assign selView   = chainBits[TABLE_DEPTH];

  AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> chainBits[CHAIN_LEN-1:1] == $past(chainBits[CHAIN_LEN-2:0])); // R1

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> $stable(chainBits)); // R2

  AST_COMB_PATH: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEn && !$past(cfgEn) && !selView) |-> cellOut == tableView[lutIn]); // R3

  AST_REG_PATH: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEn && !$past(cfgEn) && !$past(cfgEn, 2) && selView)
      |-> cellOut == $past(tableView[lutIn])); // R4

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |-> !cellOut); // R5

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgEn) |=> regQ == $past(chainBits[CHAIN_LEN-1])); // R6

  AST_REG_HOLD_CFG: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> $stable(regQ)); // R6

  AST_TAIL_OUT: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> cfgOut == $past(chainBits[CHAIN_LEN-2])); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (chainBits == '0 && !regQ && !cfgOut)); // R8

endmodule

bind logic_tile_cell logic_tile_cell_checker #(
  .LUT_INPUTS (LUT_INPUTS)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .cfgEn     (cfgEn),
  .lutIn     (lutIn),
  .cfgOut    (cfgOut),
  .cellOut   (cellOut),
  .chainBits (chainBits),
  .regQ      (regQ)
);

// File: tb/logic_tile_cell_bench.sv
module logic_tile_cell_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_IN       = 4;
  localparam int DEPTH      = 1 << N_IN;
  localparam int CLEN       = DEPTH + 2;
  localparam int WATCHDOG   = 5000;

  logic            clk   = 1'b0;
  logic            rstN  = 1'b0;
  logic            cfgEn = 1'b0;
  logic            cfgIn = 1'b0;
  logic [N_IN-1:0] lutIn = '0;
  logic            cfgOut;
  logic            cellOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_tile_cell #(.LUT_INPUTS(N_IN)) u_logic_tile_cell (
    .clk     (clk),
    .rstN    (rstN),
    .cfgEn   (cfgEn),
    .cfgIn   (cfgIn),
    .lutIn   (lutIn),
    .cfgOut  (cfgOut),
    .cellOut (cellOut)
  );

  typedef struct {
    logic  expCell;
    logic  expCfg;
    string tag;
  } sbItem_t;

  sbItem_t sbq[$];
  int checks   = 0;
  int failures = 0;

  // Reference model, built from the requirements.
  logic [CLEN-1:0] mChain = '0;
  logic            mReg   = 1'b0;
  logic            mEnQ   = 1'b0;
  logic            pEn    = 1'b0;
  logic            pBit   = 1'b0;
  logic [N_IN-1:0] pIn    = '0;

  task automatic judge(input logic act, input logic exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mChain = '0; mReg = 1'b0; mEnQ = 1'b0;
    pEn = 1'b0; pBit = 1'b0; pIn = '0;
  endtask

  // Driver: one call per cycle, at the falling edge.
  task automatic cyc(input logic en, input logic b, input logic [N_IN-1:0] ins,
                     input bit chk, input string tag);
    logic expCell;
    @(negedge clk);
    // Apply the rising edge that just passed, using the inputs held across it.
    if (pEn) begin
      mChain = {mChain[CLEN-2:0], pBit};
    end else if (mEnQ) begin
      mReg = mChain[CLEN-1];
    end else begin
      mReg = mChain[pIn];
    end
    mEnQ = pEn;
    cfgEn = en; cfgIn = b; lutIn = ins;
    pEn = en; pBit = b; pIn = ins;
    if (en || mEnQ)          expCell = 1'b0;
    else if (mChain[DEPTH])  expCell = mReg;
    else                     expCell = mChain[ins];
    if (chk) sbq.push_back('{expCell, mChain[CLEN-1], tag});
  endtask

  // Serial load: initial value first, then select, then entries 15 down to 0.
  task automatic loadCfg(input logic [DEPTH-1:0] tbl, input logic selB, input logic initB);
    cyc(1'b1, initB, 4'h5, 1'b1, "R1 R5 R7 shift init bit");
    cyc(1'b1, selB,  4'hA, 1'b1, "R1 R5 R7 shift select bit");
    for (int k = DEPTH-1; k >= 0; k--) begin
      cyc(1'b1, tbl[k], N_IN'(k), 1'b1, "R1 R5 R7 shift table bit");
    end
  endtask

  // Monitor: compares a quarter period after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (sbq.size() > 0) begin
        sbItem_t it;
        it = sbq.pop_front();
        judge(cellOut, it.expCell, "cellOut", it.tag);
        judge(cfgOut,  it.expCfg,  "cfgOut",  it.tag);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    modelReset();
    repeat (2) @(negedge clk);
    #1;
    judge(cellOut, 1'b0, "cellOut", "R8 in reset");
    judge(cfgOut,  1'b0, "cfgOut",  "R8 in reset");
    @(negedge clk);
    rstN = 1'b1;
    cyc(1'b0, 1'b1, 4'hF, 1'b1, "R8 after reset");

    // Combinational parity function, initial value 1.
    loadCfg(16'h6996, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 4'h3, 1'b1, "R5 low through release cycle");
    for (int k = 0; k < DEPTH; k++) begin
      cyc(1'b0, k[0], N_IN'(k), 1'b1, "R3 R1 R2 comb entry");
    end

    // Registered mode: initial value 1 against a table entry 0 on the same edge.
    loadCfg(16'hC35A, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 4'h0, 1'b1, "R5 low through release cycle");
    cyc(1'b0, 1'b0, 4'h2, 1'b1, "R6 init wins over capture");
    for (int k = 0; k < DEPTH; k++) begin
      cyc(1'b0, ~k[1], N_IN'((k * 7) % DEPTH), 1'b1, "R4 R2 registered entry");
    end

    // Registered mode with initial value 0 and an all-ones table.
    loadCfg(16'hFFFF, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 4'h9, 1'b1, "R5 low through release cycle");
    cyc(1'b0, 1'b1, 4'h9, 1'b1, "R6 init zero loaded");
    cyc(1'b0, 1'b0, 4'h4, 1'b1, "R4 capture after init");

    // Daisy-chain view: a new stream pushes the previous one out of cfgOut.
    loadCfg(16'h0F0F, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 4'h4, 1'b1, "R7 R5 release");
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 1'b1, N_IN'(k + 4), 1'b1, "R2 R3 cfgIn ignored");
    end

    // Asynchronous reset in the middle of operation.
    @(negedge clk);
    #1;
    rstN = 1'b0;
    #1;
    judge(cellOut, 1'b0, "cellOut", "R8 async clear");
    judge(cfgOut,  1'b0, "cfgOut",  "R8 async clear");
    cfgEn = 1'b0; cfgIn = 1'b0; lutIn = '0;
    modelReset();
    @(negedge clk);
    rstN = 1'b1;
    cyc(1'b0, 1'b0, 4'h0, 1'b1, "R8 cleared table reads 0");

    repeat (2) @(negedge clk);
    #(CLK_PERIOD/2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule